// File: doc/BRIEF.md
# Video RAM Serial Register Reload Scheduler

This block decides when the frame buffer's serial shift register must be refilled from the memory array, and from which row. It runs on the dot clock. It watches the horizontal and vertical blanking inputs, keeps a 12-bit repaint row pointer (one unit equals 1 KiB of linear address), and issues one read-transfer request at a time to a memory sequencer. Each request carries a type (whole register or half register) and a row address. The request stays up until the sequencer answers with a done pulse.

Two refill policies are available. When the line-reload bit is low, the block loads the whole register once per frame during vertical blanking. After that it issues a half-register transfer each time an internal fill counter shows that half of the register has been shifted out. The fill counter stands in for the memory's own half indicator. When the line-reload bit is high, the block reloads the whole register at the start of every horizontal blanking interval and steps the row pointer by a half or a quarter row per line. A buffer-select bit picks the frame start row: zero for buffer 0, or a parameter base for buffer 1.

Top module: `vram_reload_sched`

## Requirements
- R1: After reset `xfer_req` is low, and it stays low while no vertical blanking edge has been seen.
- R2: On the rising edge of `vblank` the row pointer is set to the frame base. The base is 0 when `disp_buf` is 0 and BUF1_BASE when it is 1. The first whole-register request of the frame carries that base.
- R3: During each vertical blanking interval the block issues exactly one whole-register request (`xfer_split`=0). Outside vertical blanking, split mode never issues one.
- R4: In split mode (`line_mode`=0) a half-register request (`xfer_split`=1) follows once the fill counter reaches SR_LEN/2. The counter is cleared when a transfer completes and counts dot clocks while `sclk_en` is high. The request rises SR_LEN/2+1 clocks after the completing edge. It is not raised again until the next transfer completes.
- R5: In split mode the pointer advances by ROW_STEP after the frame's whole-register transfer, and by ROW_STEP/2 after each half-register transfer.
- R6: In split mode horizontal blanking causes no request. Shifting clocks during horizontal blanking do not count, so the next half-register request is delayed by the length of the blanking interval.
- R7: In line mode (`line_mode`=1) a rising edge of `hblank` outside vertical blanking produces a whole-register request at the current pointer. Each completed transfer advances the pointer by ROW_STEP/2 when `quarter_step`=0, or by ROW_STEP/4 when it is 1. No half-register request is ever made in this mode.
- R8: A request holds its type and address until `xfer_done` is sampled high with it, and it drops on the next clock. Only one request is outstanding at a time. A `xfer_done` pulse while no request is pending has no effect on the pointer.
- R9: `sclk_en` is low whenever `hblank` or `vblank` is high, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Vertical blanking, active high |
| hblank | input | 1 | Horizontal blanking, active high |
| line_mode | input | 1 | 0: split refill policy, 1: reload every line |
| quarter_step | input | 1 | Line mode step size: 0 half row, 1 quarter row |
| disp_buf | input | 1 | Displayed buffer select, sampled at the vblank rise |
| xfer_done | input | 1 | Sequencer completion pulse |
| xfer_req | output | 1 | Transfer request, held until done |
| xfer_split | output | 1 | 0: whole-register transfer, 1: half-register transfer |
| xfer_addr | output | ADDR_W | Row address of the requested transfer |
| sclk_en | output | 1 | Serial clock enable, low during any blanking |

## Verification
The bench builds the block with a 16-clock shift register, a row step of 4 and a buffer-1 base of 0x200. With a half threshold of 8 clocks, every half-register request falls within a few dozen cycles, so exact trigger cycles and horizontal-blank stretching can be measured cycle by cycle. A row step of 4 keeps half and quarter steps as whole numbers (2 and 1), which makes every pointer increment visible in the request addresses. It also shows that the first increment of a frame differs from the later ones.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [1:0] {
    STEP_ROW  = 2'd0,
    STEP_HALF = 2'd1,
    STEP_QTR  = 2'd2
  } step_e;

  // pointer increment for one completed transfer, in row-address units
  function automatic int unsigned step_units(step_e k, int unsigned row_step);
    case (k)
      STEP_ROW:  return row_step;
      STEP_HALF: return row_step / 2;
      default:   return row_step / 4;
    endcase
  endfunction
endpackage

// File: rtl/vrs_fill_counter.sv
module vrs_fill_counter #(
  parameter int SR_LEN = 512,
  localparam int CNT_W = $clog2(SR_LEN + 1),
  localparam int HALF_LEN = SR_LEN / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  output logic [CNT_W-1:0] cnt,
  output logic             half_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (shift_en && cnt != CNT_W'(SR_LEN)) cnt <= cnt + 1'b1;
  end

  assign half_hit = (cnt >= CNT_W'(HALF_LEN));
endmodule

// File: rtl/vrs_row_tracker.sv
module vrs_row_tracker #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)           row <= '0;
    else if (frame_start) row <= base;
    else if (adv)         row <= row + step;
  end
endmodule

// File: rtl/vrs_req_ctl.sv
module vrs_req_ctl
  import vrs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ROW_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              vblank,
  input  logic              line_mode,
  input  logic              quarter_step,
  input  logic              half_hit,
  input  logic              accept,
  input  logic [ADDR_W-1:0] row,
  output logic              req,
  output logic              split,
  output logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] step
);
  logic  need_full, line_pend, loaded, fired;
  step_e step_q;
  step_e line_step;

  assign line_step = quarter_step ? STEP_QTR : STEP_HALF;
  assign step      = ADDR_W'(step_units(step_q, ROW_STEP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req       <= 1'b0;
      split     <= 1'b0;
      req_addr  <= '0;
      step_q    <= STEP_ROW;
      need_full <= 1'b0;
      line_pend <= 1'b0;
      loaded    <= 1'b0;
      fired     <= 1'b0;
    end else begin
      if (accept) begin
        req   <= 1'b0;
        fired <= 1'b0;
        if (!split) loaded <= 1'b1;
      end
      if (!req) begin
        if (need_full && vblank) begin
          req       <= 1'b1;
          split     <= 1'b0;
          req_addr  <= row;
          step_q    <= line_mode ? line_step : STEP_ROW;
          need_full <= 1'b0;
        end else if (line_mode && line_pend && !vblank) begin
          req       <= 1'b1;
          split     <= 1'b0;
          req_addr  <= row;
          step_q    <= line_step;
          line_pend <= 1'b0;
        end else if (!line_mode && loaded && !vblank && half_hit && !fired) begin
          req      <= 1'b1;
          split    <= 1'b1;
          req_addr <= row;
          step_q   <= STEP_HALF;
          fired    <= 1'b1;
        end
      end
      if (line_start && line_mode && !vblank) line_pend <= 1'b1;
      if (frame_start) begin
        need_full <= 1'b1;
        loaded    <= 1'b0;
        line_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vram_reload_sched.sv
module vram_reload_sched #(
  parameter int ADDR_W    = 12,
  parameter int SR_LEN    = 512,
  parameter int ROW_STEP  = 4,
  parameter int BUF1_BASE = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank,
  input  logic              hblank,
  input  logic              line_mode,
  input  logic              quarter_step,
  input  logic              disp_buf,
  input  logic              xfer_done,
  output logic              xfer_req,
  output logic              xfer_split,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              sclk_en
);
  localparam int CNT_W = $clog2(SR_LEN + 1);
  localparam logic [ADDR_W-1:0] BUF1_ROW = ADDR_W'(BUF1_BASE);

  logic              vb_q, hb_q;
  logic              frame_start, line_start, accept, half_hit;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] base, rp_addr, step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_q <= 1'b0;
      hb_q <= 1'b0;
    end else begin
      vb_q <= vblank;
      hb_q <= hblank;
    end
  end

  assign frame_start = vblank & ~vb_q;
  assign line_start  = hblank & ~hb_q;
  assign accept      = xfer_req & xfer_done;
  assign sclk_en     = ~hblank & ~vblank;
  assign base        = disp_buf ? BUF1_ROW : '0;

  vrs_fill_counter #(.SR_LEN(SR_LEN)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(accept), .shift_en(sclk_en),
    .cnt(cnt), .half_hit(half_hit)
  );

  vrs_row_tracker #(.ADDR_W(ADDR_W)) u_row (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .base(base),
    .adv(accept), .step(step), .row(rp_addr)
  );

  vrs_req_ctl #(.ADDR_W(ADDR_W), .ROW_STEP(ROW_STEP)) u_ctl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .vblank(vblank), .line_mode(line_mode), .quarter_step(quarter_step),
    .half_hit(half_hit), .accept(accept), .row(rp_addr),
    .req(xfer_req), .split(xfer_split), .req_addr(xfer_addr), .step(step)
  );
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
  parameter int ADDR_W = 12,
  parameter int SR_LEN = 512,
  localparam int CNT_W = $clog2(SR_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vblank,
  input logic              line_mode,
  input logic              xfer_req,
  input logic              xfer_done,
  input logic              xfer_split,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              sclk_en,
  input logic              accept,
  input logic              frame_start,
  input logic [ADDR_W-1:0] base,
  input logic [ADDR_W-1:0] rp_addr,
  input logic [CNT_W-1:0]  cnt
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr) && $stable(xfer_split));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> !xfer_req);

  p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> rp_addr == $past(base));

  p_split_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) && xfer_split |-> !vblank && !line_mode);

  p_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en && !accept |=> $stable(cnt));

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SR_LEN));

  p_adv_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !frame_start |=> $stable(rp_addr));
endmodule

bind vram_reload_sched vrs_checker #(.ADDR_W(ADDR_W), .SR_LEN(SR_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .line_mode(line_mode),
  .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_split(xfer_split),
  .xfer_addr(xfer_addr), .sclk_en(sclk_en), .accept(accept),
  .frame_start(frame_start), .base(base), .rp_addr(rp_addr), .cnt(cnt)
);

// File: tb/tb_vram_reload_sched.sv
module tb_vram_reload_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int SR_LEN = 16;
  localparam int ROW    = 4;
  localparam int B1     = 'h200;
  localparam int HALF   = SR_LEN / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vblank = 0, hblank = 0, line_mode = 0, quarter_step = 0, disp_buf = 0, xfer_done = 0;
  logic xfer_req, xfer_split, sclk_en;
  logic [ADDR_W-1:0] xfer_addr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_reload_sched #(.ADDR_W(ADDR_W), .SR_LEN(SR_LEN), .ROW_STEP(ROW), .BUF1_BASE(B1)) dut (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .hblank(hblank), .line_mode(line_mode),
    .quarter_step(quarter_step), .disp_buf(disp_buf), .xfer_done(xfer_done),
    .xfer_req(xfer_req), .xfer_split(xfer_split), .xfer_addr(xfer_addr), .sclk_en(sclk_en)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wait for a request, check it, hold it a little, then complete it
  task automatic serve(bit exp_split, int exp_addr, string tag);
    int t = 0;
    logic [ADDR_W-1:0] a0;
    while (!xfer_req && t < 2000) begin @(negedge clk); t++; end
    check(xfer_req, {tag, " request seen"}, int'(xfer_req), 1);
    check(xfer_split == exp_split, {tag, " type"}, int'(xfer_split), int'(exp_split));
    check(int'(xfer_addr) == exp_addr, {tag, " address"}, int'(xfer_addr), exp_addr);
    a0 = xfer_addr;
    repeat (2) begin
      @(negedge clk);
      check(xfer_req && xfer_addr == a0, "R8 held until done", int'(xfer_addr), int'(a0));
    end
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(!xfer_req, "R8 drops after done", int'(xfer_req), 0);
  endtask

  task automatic start_frame(bit buf_sel);
    disp_buf = buf_sel;
    vblank = 1'b1;
    @(negedge clk);
    check(!sclk_en, "R9 sclk off in vblank", int'(sclk_en), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!xfer_req, "R1 reset request low", int'(xfer_req), 0);
    check(sclk_en, "R9 sclk on when not blanking", int'(sclk_en), 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (xfer_req) check(0, "R1 no request before frame", 1, 0);
    end
    check(!xfer_req, "R1 idle", int'(xfer_req), 0);
  endtask

  task automatic t_split_frame;
    int n;
    line_mode = 1'b0;
    start_frame(1'b0);
    serve(1'b0, 0, "R2 R3 frame load buf0");
    repeat (5) @(negedge clk);
    check(!xfer_req, "R3 single load per vblank", int'(xfer_req), 0);
    vblank = 1'b0;
    serve(1'b1, ROW, "R5 first split after full row");
    n = 0;
    while (!xfer_req && n < 200) begin @(negedge clk); n++; end
    check(n == HALF + 1, "R4 split trigger cycle", n, HALF + 1);
    serve(1'b1, ROW + ROW/2, "R5 half row step");
    hblank = 1'b1;
    n = 0;
    while (!xfer_req && n < 200) begin
      @(negedge clk); n++;
      if (n <= 5 && xfer_req) check(0, "R6 no request in hblank", 1, 0);
      if (n == 5) hblank = 1'b0;
    end
    check(n == HALF + 1 + 5, "R6 hblank delays split", n, HALF + 6);
    serve(1'b1, ROW + 2*(ROW/2), "R5 third split");
    check(sclk_en, "R9 sclk on", int'(sclk_en), 1);
    hblank = 1'b1; @(negedge clk);
    check(!sclk_en, "R9 sclk off in hblank", int'(sclk_en), 0);
    hblank = 1'b0;
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      if (xfer_req && !xfer_split) check(0, "R3 no full load outside vblank", 1, 0);
    end
    serve(1'b1, ROW + 3*(ROW/2), "R4 refire after clear");
  endtask

  task automatic t_buf1;
    line_mode = 1'b0;
    start_frame(1'b1);
    serve(1'b0, B1, "R2 frame load buf1");
    vblank = 1'b0;
    serve(1'b1, B1 + ROW, "R5 buf1 first split");
  endtask

  task automatic line_pulse;
    hblank = 1'b1; @(negedge clk); hblank = 1'b0;
  endtask

  task automatic t_line(bit q);
    int st;
    st = q ? ROW/4 : ROW/2;
    line_mode = 1'b1;
    quarter_step = q;
    start_frame(1'b0);
    serve(1'b0, 0, "R7 line mode frame load");
    vblank = 1'b0;
    line_pulse();
    serve(1'b0, st, "R7 first line reload");
    for (int i = 0; i < 3*HALF; i++) begin
      @(negedge clk);
      if (xfer_req) check(0, "R7 no split in line mode", 1, 0);
    end
    line_pulse();
    serve(1'b0, 2*st, "R7 second line reload");
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    check(!xfer_req, "R8 stray done no request", int'(xfer_req), 0);
    line_pulse();
    serve(1'b0, 3*st, "R8 stray done ignored");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_split_frame();
    t_buf1();
    t_line(1'b0);
    t_line(1'b1);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule